// File: doc/BRIEF.md
# Checkpointed Register Rename Map

This block keeps the renaming state of an out-of-order core as a table indexed by physical register. Every entry holds the number of the architectural register it currently stands for, plus a valid bit. Source operands are translated by associative search: a lookup port presents an architectural number and receives the index of the one valid entry that holds it. A rename request names an architectural register and the physical register allocated for it. It clears whichever entry held that architectural number before and makes the new entry valid, all in one cycle. Free-list management and the reorder buffer sit outside this block.

When a branch is taken, the front end saves a checkpoint. Each checkpoint holds a full copy of the table. Checkpoint slots fill in order, and the slot a save will use is shown on `ckpt_save_idx`. When a misprediction is detected, a restore with a slot index reloads the whole table from that slot in a single cycle. The same restore releases that slot and every slot filled after it.

The rename request is a valid/ready channel. A rename is accepted on a rising clock edge where both `ren_valid` and `ren_ready` are high. `ren_ready` drops in any cycle that carries a restore command. A requester that sees `ren_ready` low must hold its request and present it again later. The lookup ports and the checkpoint commands are plain signals, and their outputs do not stall.

Top module: `rename_map_ckpt`

## Requirements
- R1: After reset, every entry is invalid. Both lookup ports report no hit for any architectural number, `ckpt_full` is 0, `ckpt_save_idx` is 0 and `ren_ready` is 1.
- R2: After a rename of architectural number A to physical tag P is accepted, a lookup of A reports a hit with tag P from the next cycle on.
- R3: A rename of A clears the entry that held A before. Afterwards only the new entry matches A, so the reported tag is exactly the new tag. Each lookup reports the index of the single matching entry.
- R4: A lookup made in the same cycle as a rename sees the table as it was before that rename.
- R5: The two lookup ports work independently and at the same time, each on its own architectural number.
- R6: A save stores a copy of the table as it stands at that edge. The copy goes into slot `ckpt_save_idx`, which equals the number of slots in use (0, 1, 2, 3 in order), and that number then rises by one.
- R7: With 4 slots in use, `ckpt_full` is 1. A further save is refused: no slot is written and the count does not change.
- R8: A restore of a slot that is in use replaces all valid bits and architectural numbers with that slot's copy. Lookups show the restored table in the next cycle.
- R9: A restore of slot k frees k and every later slot. `ckpt_save_idx` becomes k and `ckpt_full` clears.
- R10: In a cycle with a restore command, `ren_ready` is 0 and no rename is accepted. The table afterwards equals the checkpoint copy.
- R11: A restore naming a slot index that is not in use has no effect on the table or on the slot count.
- R12: If a save and a restore arrive in the same cycle, the restore wins and the save is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_arch | input | ARCH_W (6) | Architectural number being renamed |
| ren_ptag | input | $clog2(NUM_PHYS) (4) | Physical register allocated to it |
| lk0_arch | input | ARCH_W (6) | Lookup port 0 architectural number |
| lk0_hit | output | 1 | Port 0 found a valid match |
| lk0_ptag | output | $clog2(NUM_PHYS) (4) | Port 0 matching physical index |
| lk1_arch | input | ARCH_W (6) | Lookup port 1 architectural number |
| lk1_hit | output | 1 | Port 1 found a valid match |
| lk1_ptag | output | $clog2(NUM_PHYS) (4) | Port 1 matching physical index |
| ckpt_save | input | 1 | Save the table into the next free slot |
| ckpt_save_idx | output | $clog2(NUM_CKPT) (2) | Slot the next save uses |
| ckpt_restore | input | 1 | Restore the table from a slot |
| ckpt_restore_idx | input | $clog2(NUM_CKPT) (2) | Slot to restore |
| ckpt_full | output | 1 | All checkpoint slots are in use |

## Verification
The assertions check several properties on every cycle. No architectural number is ever held by more than one valid entry. An accepted rename always lands in the addressed entry. An accepted restore copies the slot's valid bits exactly. The slot count never passes its limit, stays put on a refused save and drops to the restored index. Only the bench scenarios can show the ordering effects. These are lookups seeing the pre-rename table, a refused save leaving the last slot untouched, restore beating both a rename and a save, and a restore of an unused slot being ignored. The bench reaches each of these through lookup results and the save index.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  parameter int unsigned RMAP_ARCH_W   = 6;
  parameter int unsigned RMAP_NUM_PHYS = 16;
  parameter int unsigned RMAP_NUM_CKPT = 4;
endpackage

// File: rtl/rmap_lookup.sv
module rmap_lookup #(
  parameter int unsigned NP = rmap_pkg::RMAP_NUM_PHYS,
  parameter int unsigned AW = rmap_pkg::RMAP_ARCH_W,
  localparam int unsigned PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NP-1:0]    ent_v,
  input  logic [NP*AW-1:0] ent_a,
  input  logic [AW-1:0]    q_arch,
  output logic            hit,
  output logic [PW-1:0]    ptag
);
  logic [NP-1:0] match;

  for (genvar g = 0; g < NP; g++) begin : g_cmp
    assign match[g] = ent_v[g] && (ent_a[g*AW +: AW] == q_arch);
  end

  // single match expected, so an OR of indices is the encoder
  always_comb begin
    ptag = '0;
    for (int i = 0; i < NP; i++) begin
      if (match[i]) ptag = ptag | PW'(i);
    end
  end

  assign hit = |match;

  // R3: the table never holds one architectural number twice
  p_one_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/rmap_ckpt_bank.sv
module rmap_ckpt_bank #(
  parameter int unsigned NP = rmap_pkg::RMAP_NUM_PHYS,
  parameter int unsigned AW = rmap_pkg::RMAP_ARCH_W,
  parameter int unsigned NC = rmap_pkg::RMAP_NUM_CKPT,
  localparam int unsigned CW = (NC > 1) ? $clog2(NC) : 1,
  localparam int unsigned NW = $clog2(NC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_req,
  input  logic             restore_req,
  input  logic [CW-1:0]     restore_idx,
  input  logic [NP-1:0]     cur_v,
  input  logic [NP*AW-1:0]  cur_a,
  output logic [CW-1:0]     save_idx,
  output logic             full,
  output logic             restore_ok,
  output logic [NP-1:0]     rest_v,
  output logic [NP*AW-1:0]  rest_a
);
  logic [NW-1:0]    used;
  logic [NP-1:0]    slot_v [NC];
  logic [NP*AW-1:0] slot_a [NC];
  logic             save_ok;

  assign full       = (used == NW'(NC));
  assign save_idx   = used[CW-1:0];
  assign restore_ok = restore_req && (NW'(restore_idx) < used);
  assign save_ok    = save_req && !restore_req && !full;
  assign rest_v     = slot_v[restore_idx];
  assign rest_a     = slot_a[restore_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)          used <= '0;
    else if (restore_ok) used <= NW'(restore_idx);
    else if (save_ok)    used <= used + NW'(1);
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NC; s++) begin
      if (save_ok && (used == NW'(s))) begin
        slot_v[s] <= cur_v;
        slot_a[s] <= cur_a;
      end
    end
  end

  p_used_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    used <= NW'(NC));
  p_full_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && full && !restore_req) |=> (used == $past(used)));
  p_restore_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restore_ok |=> (used == NW'($past(restore_idx))));
  p_save_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (save_req && !restore_req && !full) |=> (used == $past(used) + NW'(1)));
endmodule

// File: rtl/rename_map_ckpt.sv
module rename_map_ckpt #(
  parameter int unsigned NUM_PHYS = rmap_pkg::RMAP_NUM_PHYS,
  parameter int unsigned ARCH_W   = rmap_pkg::RMAP_ARCH_W,
  parameter int unsigned NUM_CKPT = rmap_pkg::RMAP_NUM_CKPT,
  localparam int unsigned PW = (NUM_PHYS > 1) ? $clog2(NUM_PHYS) : 1,
  localparam int unsigned CW = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_valid,
  output logic              ren_ready,
  input  logic [ARCH_W-1:0] ren_arch,
  input  logic [PW-1:0]     ren_ptag,
  input  logic [ARCH_W-1:0] lk0_arch,
  output logic              lk0_hit,
  output logic [PW-1:0]     lk0_ptag,
  input  logic [ARCH_W-1:0] lk1_arch,
  output logic              lk1_hit,
  output logic [PW-1:0]     lk1_ptag,
  input  logic              ckpt_save,
  output logic [CW-1:0]     ckpt_save_idx,
  input  logic              ckpt_restore,
  input  logic [CW-1:0]     ckpt_restore_idx,
  output logic              ckpt_full
);
  localparam int unsigned AW = ARCH_W;
  localparam int unsigned NP = NUM_PHYS;

  logic [NP-1:0]    ent_v;
  logic [NP*AW-1:0] ent_a;
  logic [NP-1:0]    old_hit;
  logic [NP-1:0]    new_bit;
  logic             ren_fire;
  logic             restore_ok;
  logic [NP-1:0]    rest_v;
  logic [NP*AW-1:0] rest_a;

  assign ren_ready = !ckpt_restore;
  assign ren_fire  = ren_valid && ren_ready;

  for (genvar g = 0; g < NP; g++) begin : g_ent
    assign old_hit[g] = ent_v[g] && (ent_a[g*AW +: AW] == ren_arch);
    assign new_bit[g] = (ren_ptag == PW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
    end else if (restore_ok) begin
      ent_v <= rest_v;
    end else if (ren_fire) begin
      ent_v <= (ent_v & ~old_hit) | new_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_a <= '0;
    end else if (restore_ok) begin
      ent_a <= rest_a;
    end else if (ren_fire) begin
      for (int i = 0; i < NP; i++) begin
        if (new_bit[i]) ent_a[i*AW +: AW] <= ren_arch;
      end
    end
  end

  rmap_lookup #(.NP(NP), .AW(AW)) u_lk0 (
    .clk(clk), .rst_n(rst_n), .ent_v(ent_v), .ent_a(ent_a),
    .q_arch(lk0_arch), .hit(lk0_hit), .ptag(lk0_ptag)
  );

  rmap_lookup #(.NP(NP), .AW(AW)) u_lk1 (
    .clk(clk), .rst_n(rst_n), .ent_v(ent_v), .ent_a(ent_a),
    .q_arch(lk1_arch), .hit(lk1_hit), .ptag(lk1_ptag)
  );

  rmap_ckpt_bank #(.NP(NP), .AW(AW), .NC(NUM_CKPT)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .save_req(ckpt_save), .restore_req(ckpt_restore),
    .restore_idx(ckpt_restore_idx),
    .cur_v(ent_v), .cur_a(ent_a),
    .save_idx(ckpt_save_idx), .full(ckpt_full),
    .restore_ok(restore_ok), .rest_v(rest_v), .rest_a(rest_a)
  );

  p_rename_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_fire && !restore_ok) |=>
      (ent_v[$past(ren_ptag)] && (ent_a[$past(ren_ptag)*AW +: AW] == $past(ren_arch))));
  p_restore_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_ok |=> (ent_v == $past(rest_v)));
  p_restore_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ckpt_restore && ren_valid && !restore_ok) |=> $stable(ent_v));
endmodule

// File: tb/sim_rename_map_ckpt.sv
module sim_rename_map_ckpt;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 1'b0;
  logic ren_ready;
  logic [5:0] ren_arch = '0;
  logic [3:0] ren_ptag = '0;
  logic [5:0] lk0_arch = '0, lk1_arch = '0;
  logic lk0_hit, lk1_hit;
  logic [3:0] lk0_ptag, lk1_ptag;
  logic ckpt_save = 1'b0, ckpt_restore = 1'b0;
  logic [1:0] ckpt_save_idx;
  logic [1:0] ckpt_restore_idx = '0;
  logic ckpt_full;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rename_map_ckpt u0 (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_arch(ren_arch), .ren_ptag(ren_ptag),
    .lk0_arch(lk0_arch), .lk0_hit(lk0_hit), .lk0_ptag(lk0_ptag),
    .lk1_arch(lk1_arch), .lk1_hit(lk1_hit), .lk1_ptag(lk1_ptag),
    .ckpt_save(ckpt_save), .ckpt_save_idx(ckpt_save_idx),
    .ckpt_restore(ckpt_restore), .ckpt_restore_idx(ckpt_restore_idx),
    .ckpt_full(ckpt_full)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // lookup on port 0; expected tag -1 means a miss
  task automatic look0(input string req, input int arch, input int exp);
    lk0_arch = 6'(arch);
    #1;
    chk({req, " hit"}, int'(lk0_hit), (exp >= 0) ? 1 : 0);
    if (exp >= 0) chk({req, " tag"}, int'(lk0_ptag), exp);
  endtask

  task automatic look1(input string req, input int arch, input int exp);
    lk1_arch = 6'(arch);
    #1;
    chk({req, " hit"}, int'(lk1_hit), (exp >= 0) ? 1 : 0);
    if (exp >= 0) chk({req, " tag"}, int'(lk1_ptag), exp);
  endtask

  task automatic rename(input int arch, input int ptag);
    @(negedge clk);
    ren_valid = 1'b1; ren_arch = 6'(arch); ren_ptag = 4'(ptag);
    @(negedge clk);
    ren_valid = 1'b0;
  endtask

  task automatic save();
    @(negedge clk);
    ckpt_save = 1'b1;
    @(negedge clk);
    ckpt_save = 1'b0;
  endtask

  task automatic restore(input int idx);
    @(negedge clk);
    ckpt_restore = 1'b1; ckpt_restore_idx = 2'(idx);
    @(negedge clk);
    ckpt_restore = 1'b0;
  endtask

  task automatic t_reset();
    look0("R1 arch0", 0, -1);
    look1("R1 arch63", 63, -1);
    chk("R1 full", int'(ckpt_full), 0);
    chk("R1 save_idx", int'(ckpt_save_idx), 0);
    chk("R1 ren_ready", int'(ren_ready), 1);
  endtask

  task automatic t_rename();
    rename(5, 3);
    look0("R2 a5", 5, 3);
    rename(9, 7);
    lk0_arch = 6'd5; lk1_arch = 6'd9;
    #1;
    chk("R5 port0 tag", int'(lk0_ptag), 3);
    chk("R5 port1 tag", int'(lk1_ptag), 7);
    chk("R5 both hit", int'(lk0_hit && lk1_hit), 1);
  endtask

  task automatic t_rebind();
    @(negedge clk);
    ren_valid = 1'b1; ren_arch = 6'd5; ren_ptag = 4'd10;
    look0("R4 old view", 5, 3);
    @(negedge clk);
    ren_valid = 1'b0;
    // a stale entry 3 would OR into the tag and give 11
    look0("R3 new tag", 5, 10);
    look1("R3 other arch kept", 9, 7);
  endtask

  task automatic t_checkpoints();
    chk("R6 first idx", int'(ckpt_save_idx), 0);
    save();                          // slot0: 5->10, 9->7
    chk("R6 idx after 1", int'(ckpt_save_idx), 1);
    rename(5, 12);
    save();                          // slot1: 5->12, 9->7
    rename(9, 2);
    save();                          // slot2: 5->12, 9->2
    chk("R6 idx after 3", int'(ckpt_save_idx), 3);
    chk("R7 not full yet", int'(ckpt_full), 0);
    save();                          // slot3: 5->12, 9->2
    chk("R7 full", int'(ckpt_full), 1);
    rename(20, 4);
    save();                          // refused
    chk("R7 still full", int'(ckpt_full), 1);
    restore(3);
    look0("R7 slot3 untouched", 20, -1);
    look1("R8 slot3 a9", 9, 2);
    chk("R9 full clears", int'(ckpt_full), 0);
    chk("R9 idx to 3", int'(ckpt_save_idx), 3);
  endtask

  task automatic t_restore_vs_rename();
    @(negedge clk);
    ckpt_restore = 1'b1; ckpt_restore_idx = 2'd1;
    ren_valid = 1'b1; ren_arch = 6'd5; ren_ptag = 4'd14;
    #1;
    chk("R10 ren_ready low", int'(ren_ready), 0);
    @(negedge clk);
    ckpt_restore = 1'b0; ren_valid = 1'b0;
    look0("R10 a5 from slot1", 5, 12);
    look1("R8 a9 from slot1", 9, 7);
    chk("R9 idx to 1", int'(ckpt_save_idx), 1);
  endtask

  task automatic t_unused_restore();
    restore(2);                      // slot2 would set a9 -> 2
    look1("R11 a9 unchanged", 9, 7);
    chk("R11 count unchanged", int'(ckpt_save_idx), 1);
  endtask

  task automatic t_save_vs_restore();
    rename(30, 8);
    @(negedge clk);
    ckpt_save = 1'b1; ckpt_restore = 1'b1; ckpt_restore_idx = 2'd0;
    @(negedge clk);
    ckpt_save = 1'b0; ckpt_restore = 1'b0;
    chk("R12 save ignored", int'(ckpt_save_idx), 0);
    look0("R12 a5 slot0", 5, 10);
    look1("R12 a30 gone", 30, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rename();
    t_rebind();
    t_checkpoints();
    t_restore_vs_rename();
    t_unused_restore();
    t_save_vs_restore();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule